// File: doc/BRIEF.md
# Integer Store Execution Unit

This block executes integer store instructions for a 32-bit RISC pipeline. Each issued instruction arrives already decoded. The fields are the access size, the addressing form (register plus signed 16-bit displacement, or register plus register), an update flag, a byte-reverse flag and the record bit. The rA register number also arrives, together with the current values of rA, rB and the source register rS.

From these the block forms the effective address. It drives a one-cycle write request on a 32-bit big-endian bus, with the data steered onto its byte lanes and the matching byte enables. For update forms it also returns the effective address as a writeback to rA.

Some instruction forms are not allowed. When one arrives, the block raises an illegal-instruction flag and does nothing else. A halfword or word store that is not naturally aligned raises an alignment flag and is also dropped. All results are registered and appear exactly one cycle after the instruction is issued.

Top module: `store_exec_unit`

## Requirements
- R1: The effective address (EA) is base + offset, modulo 2^32. The base is 0 when `ra_idx` is 0 and `ra_val` otherwise. The offset is `rb_val` when `indexed`=1, and the sign-extended `disp` when `indexed`=0. A performed store presents the EA on `mem_addr`.
- R2: A byte store (`size`=00) enables one lane. The bus lane for byte address offset o (o = EA[1:0]) is bits [31-8o:24-8o] with enable bit `mem_be[3-o]`. That lane carries `rs_val[7:0]` and all other data bits are zero.
- R3: A halfword store (`size`=01) enables lanes o and o+1. Without reversal, lane o carries `rs_val[15:8]` and lane o+1 carries `rs_val[7:0]`.
- R4: A word store (`size`=10) enables all four lanes. Without reversal, `mem_wdata` equals `rs_val`.
- R5: When `byte_rev`=1, the bytes of a halfword or word are written in the opposite order, so the least significant byte of rS goes to the lowest address. `byte_rev` has no effect on byte stores.
- R6: A performed store with `update`=1 raises `wb_valid` in the same cycle as `mem_wr_valid`, with `wb_idx`=`ra_idx` and `wb_data`=EA. A store with `update`=0 never raises `wb_valid`.
- R7: When rS and rA are the same register in an update form, memory receives the value that register held before the update. The EA goes only to the writeback.
- R8: A form is illegal when `rc_bit`=1, when `size`=11, or when `update`=1 with `ra_idx`=0. An illegal form raises `illegal_flag` for one cycle and produces no memory write and no writeback.
- R9: A legal halfword at an odd address, or a legal word with EA[1:0]≠0, raises `align_flag` and produces no write and no writeback. An illegal form never raises `align_flag`.
- R10: Outputs change one cycle after a clock edge with `issue_valid`=1. Each strobe lasts one cycle, and no strobe is raised in a cycle that follows an edge without an issue.
- R11: During and right after reset, all four strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | A store instruction is issued this cycle |
| size | input | 2 | 00 byte, 01 halfword, 10 word, 11 reserved |
| indexed | input | 1 | 1: offset from rB, 0: displacement |
| update | input | 1 | Update form: write EA back to rA |
| byte_rev | input | 1 | Store with reversed byte order |
| rc_bit | input | 1 | Record bit of the instruction |
| ra_idx | input | 5 | rA register number |
| ra_val | input | 32 | Value of rA |
| rb_val | input | 32 | Value of rB |
| rs_val | input | 32 | Value of rS |
| disp | input | 16 | Signed displacement |
| mem_wr_valid | output | 1 | One-cycle write request |
| mem_addr | output | 32 | Effective byte address |
| mem_be | output | 4 | Byte enables, bit 3 = lowest address |
| mem_wdata | output | 32 | Lane-steered write data |
| wb_valid | output | 1 | One-cycle writeback strobe |
| wb_idx | output | 5 | Writeback register number |
| wb_data | output | 32 | Writeback value (EA) |
| illegal_flag | output | 1 | Illegal form detected |
| align_flag | output | 1 | Misaligned halfword or word |

## Verification
Two functions can fall on the same instruction: the illegal-form check and the alignment check. Likewise, the memory write and the rA writeback share one cycle. The bench sweeps every size, every address offset, both addressing forms, and each state of the update, reverse, record and rA-zero controls. This produces instructions that are both illegal and misaligned. For those, the bench expects only `illegal_flag`. Where a store is legal, aligned and an update form, it expects the write request and the writeback in the same cycle with matching addresses. A directed case aliases rS to rA to confirm that the stored data is the old register value.

// File: rtl/store_exec_pkg.sv
package store_exec_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } st_size_e;

  // number of memory bytes touched by an access of the given size
  function automatic int access_bytes(st_size_e s);
    case (s)
      SZ_BYTE: return 1;
      SZ_HALF: return 2;
      SZ_WORD: return 4;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/store_agen.sv
module store_agen #(
  parameter int XLEN   = 32,
  parameter int DISP_W = 16
) (
  input  logic              indexed,
  input  logic              ra_is_zero,
  input  logic [XLEN-1:0]   ra_val,
  input  logic [XLEN-1:0]   rb_val,
  input  logic [DISP_W-1:0] disp,
  output logic [XLEN-1:0]   ea
);

  function automatic logic [XLEN-1:0] sign_extend(logic [DISP_W-1:0] d);
    return {{(XLEN-DISP_W){d[DISP_W-1]}}, d};
  endfunction

  function automatic logic [XLEN-1:0] form_ea(logic idx, logic zero_base,
                                              logic [XLEN-1:0] a, logic [XLEN-1:0] b,
                                              logic [DISP_W-1:0] d);
    logic [XLEN-1:0] base, ofs;
    base = zero_base ? '0 : a;
    ofs  = idx ? b : sign_extend(d);
    return base + ofs;
  endfunction

  assign ea = form_ea(indexed, ra_is_zero, ra_val, rb_val, disp);

endmodule

// File: rtl/store_lane_steer.sv
module store_lane_steer
  import store_exec_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int NLANE = XLEN / 8,
  parameter int OFS_W = $clog2(NLANE)
) (
  input  st_size_e          size,
  input  logic              byte_rev,
  input  logic [OFS_W-1:0]  offset,
  input  logic [XLEN-1:0]   rs_val,
  output logic [NLANE-1:0]  be,
  output logic [XLEN-1:0]   wdata
);

  int nbytes;
  assign nbytes = access_bytes(size);

  // lane l holds memory byte (l - offset) of the access; big-endian lane order
  for (genvar l = 0; l < NLANE; l++) begin : g_lane
    int rel;
    logic [OFS_W-1:0] src;
    logic lane_on;
    assign rel     = l - int'(offset);
    assign lane_on = (rel >= 0) && (rel < nbytes);
    assign src     = OFS_W'(byte_rev ? rel : nbytes - 1 - rel);
    assign be[NLANE-1-l] = lane_on;
    assign wdata[XLEN-1-8*l -: 8] = lane_on ? rs_val[{src, 3'b000} +: 8] : 8'h00;
  end

endmodule

// File: rtl/store_form_check.sv
module store_form_check
  import store_exec_pkg::*;
#(
  parameter int RIDX_W = 5,
  parameter int OFS_W  = 2
) (
  input  st_size_e          size,
  input  logic              update,
  input  logic              rc_bit,
  input  logic [RIDX_W-1:0] ra_idx,
  input  logic [OFS_W-1:0]  offset,
  output logic              illegal,
  output logic              misaligned
);

  function automatic logic is_illegal(st_size_e s, logic upd, logic rc, logic [RIDX_W-1:0] ra);
    return rc || (s == SZ_RSVD) || (upd && (ra == '0));
  endfunction

  function automatic logic is_misaligned(st_size_e s, logic [OFS_W-1:0] o);
    case (s)
      SZ_HALF: return o[0];
      SZ_WORD: return o[1:0] != 2'b00;
      default: return 1'b0;
    endcase
  endfunction

  assign illegal    = is_illegal(size, update, rc_bit, ra_idx);
  assign misaligned = is_misaligned(size, offset);

endmodule

// File: rtl/store_exec_unit.sv
module store_exec_unit
  import store_exec_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int DISP_W = 16,
  parameter int RIDX_W = 5,
  localparam int NLANE = XLEN / 8,
  localparam int OFS_W = $clog2(NLANE)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_valid,
  input  logic [1:0]        size,
  input  logic              indexed,
  input  logic              update,
  input  logic              byte_rev,
  input  logic              rc_bit,
  input  logic [RIDX_W-1:0] ra_idx,
  input  logic [XLEN-1:0]   ra_val,
  input  logic [XLEN-1:0]   rb_val,
  input  logic [XLEN-1:0]   rs_val,
  input  logic [DISP_W-1:0] disp,
  output logic              mem_wr_valid,
  output logic [XLEN-1:0]   mem_addr,
  output logic [NLANE-1:0]  mem_be,
  output logic [XLEN-1:0]   mem_wdata,
  output logic              wb_valid,
  output logic [RIDX_W-1:0] wb_idx,
  output logic [XLEN-1:0]   wb_data,
  output logic              illegal_flag,
  output logic              align_flag
);

  st_size_e size_e;
  assign size_e = st_size_e'(size);

  // named internal events
  logic [XLEN-1:0]  ea;
  logic [NLANE-1:0] lane_be;
  logic [XLEN-1:0]  lane_data;
  logic             form_bad, addr_bad;
  logic             do_store, do_wb, raise_illegal, raise_align;

  store_agen #(.XLEN(XLEN), .DISP_W(DISP_W)) u_agen (
    .indexed    (indexed),
    .ra_is_zero (ra_idx == '0),
    .ra_val     (ra_val),
    .rb_val     (rb_val),
    .disp       (disp),
    .ea         (ea)
  );

  store_lane_steer #(.XLEN(XLEN)) u_steer (
    .size     (size_e),
    .byte_rev (byte_rev),
    .offset   (ea[OFS_W-1:0]),
    .rs_val   (rs_val),
    .be       (lane_be),
    .wdata    (lane_data)
  );

  store_form_check #(.RIDX_W(RIDX_W), .OFS_W(OFS_W)) u_check (
    .size       (size_e),
    .update     (update),
    .rc_bit     (rc_bit),
    .ra_idx     (ra_idx),
    .offset     (ea[OFS_W-1:0]),
    .illegal    (form_bad),
    .misaligned (addr_bad)
  );

  assign raise_illegal = issue_valid && form_bad;
  assign raise_align   = issue_valid && !form_bad && addr_bad;
  assign do_store      = issue_valid && !form_bad && !addr_bad;
  assign do_wb         = do_store && update;

  // rS value is captured at issue, so an aliased rA sees the old value in memory
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_wr_valid <= 1'b0;
      wb_valid     <= 1'b0;
      illegal_flag <= 1'b0;
      align_flag   <= 1'b0;
      mem_addr     <= '0;
      mem_be       <= '0;
      mem_wdata    <= '0;
      wb_idx       <= '0;
      wb_data      <= '0;
    end else begin
      mem_wr_valid <= do_store;
      wb_valid     <= do_wb;
      illegal_flag <= raise_illegal;
      align_flag   <= raise_align;
      if (do_store) begin
        mem_addr  <= ea;
        mem_be    <= lane_be;
        mem_wdata <= lane_data;
      end
      if (do_wb) begin
        wb_idx  <= ra_idx;
        wb_data <= ea;
      end
    end
  end

  assert_strobe_after_issue_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_valid || wb_valid || illegal_flag || align_flag) |-> $past(issue_valid));

  assert_illegal_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_flag |-> (!mem_wr_valid && !wb_valid && !align_flag));

  assert_align_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    align_flag |-> (!mem_wr_valid && !wb_valid));

  assert_wb_with_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (mem_wr_valid && wb_idx != '0 && wb_data == mem_addr));

  assert_be_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_valid |-> ($countones(mem_be) == access_bytes(st_size_e'($past(size)))));

  assert_natural_align_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_valid && $countones(mem_be) > 1) |-> (mem_addr[0] == 1'b0));

  assert_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (illegal_flag && !issue_valid) |=> !illegal_flag);

endmodule

// File: tb/store_exec_unit_bench.sv
module store_exec_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        issue_valid;
  logic [1:0]  size;
  logic        indexed, update, byte_rev, rc_bit;
  logic [4:0]  ra_idx;
  logic [31:0] ra_val, rb_val, rs_val;
  logic [15:0] disp;
  logic        mem_wr_valid, wb_valid, illegal_flag, align_flag;
  logic [31:0] mem_addr, mem_wdata, wb_data;
  logic [3:0]  mem_be;
  logic [4:0]  wb_idx;

  int checks = 0;
  int errors = 0;
  logic [31:0] seed = 32'h1234_5678;

  always #5 clk = ~clk;

  store_exec_unit u_store_exec_unit (
    .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .size(size),
    .indexed(indexed), .update(update), .byte_rev(byte_rev), .rc_bit(rc_bit),
    .ra_idx(ra_idx), .ra_val(ra_val), .rb_val(rb_val), .rs_val(rs_val), .disp(disp),
    .mem_wr_valid(mem_wr_valid), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .wb_valid(wb_valid), .wb_idx(wb_idx), .wb_data(wb_data),
    .illegal_flag(illegal_flag), .align_flag(align_flag)
  );

  function automatic logic [31:0] rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return {seed[15:0], seed[31:16]} ^ (seed >> 7);
  endfunction

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic strobes_low(input string req);
    check(!mem_wr_valid, req, 32'(mem_wr_valid), 0);
    check(!wb_valid,     req, 32'(wb_valid), 0);
    check(!illegal_flag, req, 32'(illegal_flag), 0);
    check(!align_flag,   req, 32'(align_flag), 0);
  endtask

  // issue at a falling edge, captured at the next rising edge, checked at the following falling edge
  task automatic run_and_check();
    logic [31:0] base, ofs, ea, xdata, xwb;
    logic [15:0] half;
    logic [3:0]  xbe;
    logic [1:0]  o;
    logic bad_form, bad_addr, ok;
    string szreq;
    base = (ra_idx == 0) ? 32'h0 : ra_val;
    ofs  = indexed ? rb_val : {{16{disp[15]}}, disp};
    ea   = base + ofs;
    o    = ea[1:0];
    half = byte_rev ? {rs_val[7:0], rs_val[15:8]} : rs_val[15:0];
    case (size)
      2'b00: begin xbe = 4'b1000 >> o; xdata = {rs_val[7:0], 24'h0} >> (8*o); szreq = "R2"; end
      2'b01: begin xbe = 4'b1100 >> o; xdata = {half, 16'h0} >> (8*o); szreq = "R3"; end
      default: begin
        xbe = 4'b1111;
        xdata = byte_rev ? {rs_val[7:0], rs_val[15:8], rs_val[23:16], rs_val[31:24]} : rs_val;
        szreq = "R4";
      end
    endcase
    if (byte_rev && size != 2'b00) szreq = {szreq, "/R5"};
    bad_form = rc_bit || size == 2'b11 || (update && ra_idx == 0);
    bad_addr = (size == 2'b01 && o[0]) || (size == 2'b10 && o != 0);
    ok = !bad_form && !bad_addr;
    xwb = ea;
    issue_valid = 1'b1;
    @(negedge clk);
    issue_valid = 1'b0;
    check(illegal_flag == bad_form, "R8 illegal", 32'(illegal_flag), 32'(bad_form));
    check(align_flag == (!bad_form && bad_addr), "R9 align", 32'(align_flag), 32'(!bad_form && bad_addr));
    check(mem_wr_valid == ok, "R8/R9/R10 write strobe", 32'(mem_wr_valid), 32'(ok));
    check(wb_valid == (ok && update), "R6 writeback strobe", 32'(wb_valid), 32'(ok && update));
    if (ok) begin
      check(mem_addr == ea, "R1 address", mem_addr, ea);
      check(mem_be == xbe, {szreq, " enables"}, 32'(mem_be), 32'(xbe));
      check(mem_wdata == xdata, {szreq, " data"}, mem_wdata, xdata);
    end
    if (ok && update) begin
      check(wb_data == xwb, "R6 wb data", wb_data, xwb);
      check(wb_idx == ra_idx, "R6 wb index", 32'(wb_idx), 32'(ra_idx));
    end
    @(negedge clk);
    strobes_low("R10 idle");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; issue_valid = 1'b0; size = 2'b00; indexed = 1'b0; update = 1'b0;
    byte_rev = 1'b0; rc_bit = 1'b0; ra_idx = 5'd0; ra_val = '0; rb_val = '0; rs_val = '0; disp = '0;
    repeat (3) @(negedge clk);
    strobes_low("R11 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    strobes_low("R11 after reset");

    for (int sz = 0; sz < 4; sz++)
      for (int off = 0; off < 4; off++)
        for (int ix = 0; ix < 2; ix++)
          for (int up = 0; up < 2; up++)
            for (int rv = 0; rv < 2; rv++)
              for (int rc = 0; rc < 2; rc++)
                for (int rs = 0; rs < 2; rs++) begin
                  size = 2'(sz); indexed = ix[0]; update = up[0]; byte_rev = rv[0];
                  rc_bit = rc[0]; ra_idx = rs[0] ? 5'd9 : 5'd0;
                  ra_val = rnd() & ~32'h3;
                  rb_val = (rnd() & ~32'h3) | 32'(off);
                  disp   = (rnd() & 16'hfffc) | 16'(off);
                  rs_val = rnd();
                  run_and_check();
                end

    // R7: rS aliased to rA in an update form, memory takes the old value
    size = 2'b10; indexed = 1'b0; update = 1'b1; byte_rev = 1'b0; rc_bit = 1'b0;
    ra_idx = 5'd5; ra_val = 32'h1000_0000; rs_val = 32'h1000_0000; disp = 16'h0008;
    issue_valid = 1'b1;
    @(negedge clk);
    issue_valid = 1'b0;
    check(mem_wdata == 32'h1000_0000, "R7 old value stored", mem_wdata, 32'h1000_0000);
    check(wb_data == 32'h1000_0008, "R7 EA written back", wb_data, 32'h1000_0008);
    @(negedge clk);

    // R1: negative displacement wraps below the base
    size = 2'b00; update = 1'b0; ra_idx = 5'd3; ra_val = 32'h0000_0002; disp = 16'hfffd;
    rs_val = 32'h0000_00a5;
    run_and_check();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule